// File: doc/BRIEF.md
# Delay Measurement Setup and Readout Scan Register

This block is the serial control point of an on-chip array of 32 devices under test that are measured for delay by random sampling. A few pins carry a single scan path. Setup words are shifted into a shadow register. Each setup word gives a device address, a driver strength code and a capacitive load code. An update strobe then moves the shadow contents into the active configuration that drives the array.

The update is checked before it is accepted. A driver strength code of zero would leave the cell under test undriven, so an update carrying it is refused. In that case the active setup is kept and a sticky error flag is raised.

At the end of a run, a capture strobe loads the four joint-event counters into the same chain. The counts are then shifted out over the scan output pin.

Top module: `dly_meas_cfg`

## Requirements
- R1: After reset the address is 0, the strength code is 001, the load code is 00, the error flag is 0, select line 0 is the only one high, and scan_out_o is 0.
- R2: While scan_en_i is high and capture_i is low, the chain moves one bit per clock toward scan_out_o, and scan_in_i enters at the far end. Shifting alone never changes dut_addr_o, slope_o, load_o, dut_sel_o or cfg_err_o.
- R3: An update takes the setup word from the last 10 bits shifted in, with the earliest bit as word bit 0. The word layout is: address in bits 4..0, strength code in bits 7..5, load code in bits 9..8.
- R4: An update whose strength code is 000 leaves address, strength code and load code unchanged, and sets cfg_err_o on the next clock.
- R5: cfg_err_o stays set until an update with a nonzero strength code is accepted. That update clears it on the same edge that applies the new setup.
- R6: dut_sel_o is one-hot, and its high bit is the one indexed by the active address.
- R7: A capture loads cnt_i into the chain. cnt_i holds four CNT_W-bit counts, with count k in bits [k*CNT_W +: CNT_W], where k is the 2-bit code {input sample, output sample}. The counts leave the chain in the order k = 0, 1, 2, 3, each least significant bit first. The first bit is on scan_out_o in the cycle right after the capture edge.
- R8: When capture_i and scan_en_i are both high in one cycle, the capture wins and no bit is shifted on that edge.
- R9: An update in the same cycle as a capture uses the shadow contents from before that edge.
- R10: All four load codes, including 00, are accepted. They pass to load_o unchanged as long as the strength code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Shift the chain by one bit |
| scan_in_i | input | 1 | Serial data in |
| capture_i | input | 1 | Load the counter values into the chain |
| update_i | input | 1 | Move the shadow setup into the active setup if it is legal |
| cnt_i | input | 4*CNT_W | Four event counts, code 00 in the low bits |
| scan_out_o | output | 1 | Serial data out |
| dut_addr_o | output | 5 | Active device address |
| slope_o | output | 3 | Active driver strength enables (weights 1, 2, 4) |
| load_o | output | 2 | Active load capacitor enables (weights 1, 2) |
| dut_sel_o | output | 32 | One-hot device select |
| cfg_err_o | output | 1 | Sticky flag for a refused update |

## Verification
Two pairs of functions can meet on one edge: capture with shift, and capture with update. The bench provokes both. In the first case, scan_en_i is held high across the capture strobe. The serial stream read back must still start at bit 0 of count 00, with no bit skipped. In the second case, a legal setup word is shifted in, and update_i and capture_i are then raised together. The counts are chosen so that their top bits would decode to strength code 000. The new setup must appear on the outputs, with no error flag, and the readout that follows must return the captured counts intact.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int N_DUT   = 32;
  localparam int ADDR_W  = $clog2(N_DUT);
  localparam int SLOPE_W = 3;
  localparam int LOAD_W  = 2;
  localparam int CFG_W   = ADDR_W + SLOPE_W + LOAD_W;
  localparam int N_CNT   = 4;

  typedef struct packed {
    logic [LOAD_W-1:0]  load;
    logic [SLOPE_W-1:0] slope;
    logic [ADDR_W-1:0]  addr;
  } cfg_t;

  localparam cfg_t CFG_RST = '{load: '0, slope: SLOPE_W'(1), addr: '0};

  function automatic logic cfg_legal(cfg_t c);
    return c.slope != '0;
  endfunction
endpackage

// File: rtl/mcfg_shift.sv
module mcfg_shift #(
  parameter int CNT_W   = 16,
  parameter int CHAIN_W = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scan_en_i,
  input  logic                       scan_in_i,
  input  logic                       capture_i,
  input  logic [mcfg_pkg::N_CNT*CNT_W-1:0] cnt_i,
  output logic [CHAIN_W-1:0]         chain_o
);
  localparam int CAP_W = mcfg_pkg::N_CNT * CNT_W;

  logic [CHAIN_W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = chain_q;
    if (capture_i) begin
      // capture has priority over shift
      chain_d = '0;
      chain_d[CAP_W-1:0] = cnt_i;
    end else if (scan_en_i) begin
      chain_d = {scan_in_i, chain_q[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/mcfg_active.sv
module mcfg_active
  import mcfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic update_i,
  input  cfg_t shadow_i,
  output cfg_t active_o,
  output logic err_o
);
  cfg_t active_q;
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= CFG_RST;
      err_q    <= 1'b0;
    end else if (update_i) begin
      if (cfg_legal(shadow_i)) begin
        active_q <= shadow_i;
        err_q    <= 1'b0;
      end else begin
        err_q    <= 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign err_o    = err_q;
endmodule

// File: rtl/mcfg_sel.sv
module mcfg_sel #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [W-1:0] addr_i,
  output logic [N-1:0] sel_o
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel_o[g] = (addr_i == W'(g));
  end
endmodule

// File: rtl/dly_meas_cfg.sv
module dly_meas_cfg
  import mcfg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scan_en_i,
  input  logic                   scan_in_i,
  input  logic                   capture_i,
  input  logic                   update_i,
  input  logic [N_CNT*CNT_W-1:0] cnt_i,
  output logic                   scan_out_o,
  output logic [ADDR_W-1:0]      dut_addr_o,
  output logic [SLOPE_W-1:0]     slope_o,
  output logic [LOAD_W-1:0]      load_o,
  output logic [N_DUT-1:0]       dut_sel_o,
  output logic                   cfg_err_o
);
  localparam int CAP_W   = N_CNT * CNT_W;
  localparam int CHAIN_W = (CAP_W > CFG_W) ? CAP_W : CFG_W;

  logic [CHAIN_W-1:0] chain_q;
  cfg_t shadow, active;

  mcfg_shift #(.CNT_W(CNT_W), .CHAIN_W(CHAIN_W)) u_shift (
    .clk_i, .rst_ni, .scan_en_i, .scan_in_i, .capture_i, .cnt_i,
    .chain_o(chain_q)
  );

  // setup word sits in the last CFG_W bits shifted in
  assign shadow = cfg_t'(chain_q[CHAIN_W-1 -: CFG_W]);

  mcfg_active u_active (
    .clk_i, .rst_ni, .update_i,
    .shadow_i(shadow),
    .active_o(active),
    .err_o   (cfg_err_o)
  );

  mcfg_sel #(.N(N_DUT), .W(ADDR_W)) u_sel (
    .addr_i(active.addr),
    .sel_o (dut_sel_o)
  );

  assign scan_out_o = chain_q[0];
  assign dut_addr_o = active.addr;
  assign slope_o    = active.slope;
  assign load_o     = active.load;
endmodule

// File: rtl/dly_meas_cfg_chk.sv
module dly_meas_cfg_chk
  import mcfg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CHAIN_W = 64
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   scan_en_i,
  input logic                   capture_i,
  input logic                   update_i,
  input logic [N_CNT*CNT_W-1:0] cnt_i,
  input logic                   scan_out_o,
  input logic [ADDR_W-1:0]      dut_addr_o,
  input logic [SLOPE_W-1:0]     slope_o,
  input logic [LOAD_W-1:0]      load_o,
  input logic [N_DUT-1:0]       dut_sel_o,
  input logic                   cfg_err_o,
  input logic [CHAIN_W-1:0]     chain_q
);
  logic [SLOPE_W-1:0] sh_slope;
  assign sh_slope = chain_q[CHAIN_W-1-LOAD_W -: SLOPE_W];

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i && !capture_i |=> scan_out_o == $past(chain_q[1]));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(dut_addr_o) && $stable(slope_o) && $stable(load_o)
                  && $stable(cfg_err_o));

  p_slope_nz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slope_o != '0);

  p_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && sh_slope == '0 |=> cfg_err_o && $stable(slope_o)
                                   && $stable(dut_addr_o) && $stable(load_o));

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && sh_slope != '0 |=> !cfg_err_o && slope_o == $past(sh_slope));

  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dut_sel_o) == 1 && dut_sel_o[dut_addr_o]);

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> scan_out_o == $past(cnt_i[0]));
endmodule

bind dly_meas_cfg dly_meas_cfg_chk #(.CNT_W(CNT_W), .CHAIN_W(CHAIN_W)) u_chk (
  .clk_i, .rst_ni, .scan_en_i, .capture_i, .update_i, .cnt_i, .scan_out_o,
  .dut_addr_o, .slope_o, .load_o, .dut_sel_o, .cfg_err_o,
  .chain_q(chain_q)
);

// File: tb/dly_meas_cfg_bench.sv
module dly_meas_cfg_bench;
  localparam int CNT_W = 16;
  localparam int CAP_W = 4 * CNT_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scan_en = 0, scan_in = 0, capture = 0, update = 0;
  logic [CAP_W-1:0] cnt = '0;
  logic scan_out, err;
  logic [4:0] addr;
  logic [2:0] slope;
  logic [1:0] load;
  logic [31:0] sel;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // model of the active setup
  logic [4:0] m_addr = '0;
  logic [2:0] m_slope = 3'd1;
  logic [1:0] m_load = '0;
  logic m_err = 0;

  always #5ns clk = ~clk;

  dly_meas_cfg #(.CNT_W(CNT_W)) u_dly_meas_cfg (
    .clk_i(clk), .rst_ni, .scan_en_i(scan_en), .scan_in_i(scan_in),
    .capture_i(capture), .update_i(update), .cnt_i(cnt),
    .scan_out_o(scan_out), .dut_addr_o(addr), .slope_o(slope),
    .load_o(load), .dut_sel_o(sel), .cfg_err_o(err)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] onehot(input logic [4:0] a);
    return 32'd1 << a;
  endfunction

  function automatic logic [11:0] model_word();
    return {m_err, m_load, m_slope, m_addr, 1'b0};
  endfunction

  task automatic chk_cfg(input string rq);
    chk(rq, {err, load, slope, addr, 1'b0}, model_word());
    chk({rq, "_R6"}, sel, onehot(m_addr));
  endtask

  task automatic apply_model(input logic [9:0] w);
    if (w[7:5] == 3'b000) m_err = 1;
    else begin
      m_addr = w[4:0]; m_slope = w[7:5]; m_load = w[9:8]; m_err = 0;
    end
  endtask

  // shift a 10-bit setup word, bit 0 first; leaves on a negedge
  task automatic shift_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) begin
      scan_en = 1; scan_in = w[i];
      @(negedge clk);
    end
    scan_en = 0; scan_in = 0;
  endtask

  task automatic load_cfg(input logic [9:0] w, input string rq);
    shift_word(w);
    chk_cfg("R2 no change while shifting");
    update = 1;
    @(negedge clk);
    update = 0;
    apply_model(w);
    chk_cfg(rq);
  endtask

  // capture c, optionally with shift and/or update in the same cycle
  task automatic read_counts(input logic [CAP_W-1:0] c, input bit with_shift,
                             input bit with_upd, input logic [9:0] w, input string rq);
    logic [CAP_W-1:0] got;
    cnt = c; capture = 1; scan_en = with_shift; update = with_upd;
    @(negedge clk);
    capture = 0; update = 0; scan_en = 1;
    if (with_upd) begin
      apply_model(w);
      chk_cfg("R9 update uses pre-capture shadow");
    end
    cnt = {$urandom, $urandom};
    for (int i = 0; i < CAP_W; i++) begin
      got[i] = scan_out;
      @(negedge clk);
    end
    scan_en = 0;
    chk(rq, got, c);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk_cfg("R1 reset setup");
    chk("R1 scan_out", {63'd0, scan_out}, 64'd0);

    // R3 field layout, R10 load code 00 kept
    load_cfg({2'b00, 3'b101, 5'd19}, "R3 field layout / R10 load 00");
    load_cfg({2'b11, 3'b111, 5'd31}, "R3 max address / R10 load 11");
    // R4 zero strength code rejected
    load_cfg({2'b10, 3'b000, 5'd7}, "R4 zero strength rejected");
    load_cfg({2'b01, 3'b000, 5'd2}, "R5 error stays sticky");
    load_cfg({2'b01, 3'b010, 5'd0}, "R5 valid update clears error");

    // R7 readout order, plain
    read_counts(64'h3333_2222_1111_0001, 0, 0, '0, "R7 readout order");
    // R8 capture with shift in same cycle
    read_counts(64'hDEAD_BEEF_0123_4567, 1, 0, '0, "R8 capture beats shift");
    // R9 update with capture: shadow holds a legal word, counts' top bits give strength 000
    shift_word({2'b10, 3'b100, 5'd9});
    read_counts(64'h0000_FFFF_A5A5_5A5A, 0, 1, {2'b10, 3'b100, 5'd9},
                "R9 readout after joint update");

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      logic [9:0] w;
      w = 10'($urandom);
      if ($urandom_range(0, 4) == 0) w[7:5] = 3'b000;
      load_cfg(w, w[7:5] == 0 ? "R4 random reject" : "R3 random setup");
      if (k % 4 == 0)
        read_counts({$urandom, $urandom}, k[3], 0, '0, "R7 random readout");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule